// File: doc/BRIEF.md
# Embedded-Clock Pixel Serial Framer

This block is the transmit-side framer of a point-to-point link that runs from a display timing controller to one column driver. On every frame it takes in one parallel pixel word, made of red, green and blue fields, together with a data-enable flag. It then produces a run of serial symbols, one for each serial strobe. A low data-enable flag marks the word as blanking or control content rather than image data.

Each symbol is a two-bit level code. The link carries no separate clock wire. Instead, two higher-amplitude clock symbols are placed in every frame, one at the start of each half. The polarity of each clock symbol copies the data bit sent just before it. A tail bit follows each clock symbol. A configuration input sets the tail bit either equal to the clock polarity (for slower links) or to its inverse (for faster links, where it reduces inter-symbol interference). The analog line driver, the frequency synthesis and the common-mode control are outside this block.

The width of each colour field is a parameter. A frame holds three times that width plus six slots, which is 36 slots for 10-bit colour. The word is sampled on the first slot of each frame. The serial strobe `ser_en` moves the framer forward by one slot.

Top module: `emb_clk_framer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sym_out` is 2'b00. After reset the frame position is slot 0, and the remembered previous data bit is 0.
- R2: Symbol codes are 2'b00 data-low, 2'b01 data-high, 2'b10 clock-low and 2'b11 clock-high. A frame is 3*DEPTH+6 symbols long. Clock codes (bit 1 set) appear only at slot 0 and at slot HALF = (3*DEPTH+6)/2, which is slot 18 for DEPTH=10.
- R3: A clock symbol's bit 0 equals the value of the data symbol emitted just before it. The first clock symbol after reset is therefore clock-low.
- R4: The symbol after each clock symbol is a data symbol (tail). When `tail_inv` is 0 its value equals the clock polarity. When `tail_inv` is 1 it is the inverse of the clock polarity.
- R5: Slot 2 is a data symbol carrying the `de_in` value that was sampled with the frame's word at slot 0.
- R6: Slots 3 to HALF-2 carry `pix_in` bits from 3*DEPTH-1 downward, MSB first. These are red (bits 29..20), then the four green MSBs (bits 19..16). Slot HALF-1 is a spare data-low. Slots HALF+2 to the end carry the remaining bits 15..0, which are six green bits and then blue. `pix_in` is packed {red, green, blue}.
- R7: `pix_in` and `de_in` are sampled only on the strobe that emits slot 0. Changing them during the rest of a frame has no effect on that frame's symbols.
- R8: With `ser_en` low, `sym_out` and the frame position hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Serial strobe; advances one slot |
| tail_inv | input | 1 | 1 = tail bit opposite to clock polarity |
| de_in | input | 1 | Data-enable flag for the word |
| pix_in | input | 3*DEPTH | Pixel or control word {R,G,B} |
| sym_out | output | 2 | Registered symbol level code |

## Verification
A walking one across all thirty word bits, run with both tail settings, shows whether any single bit is sent in the wrong slot or lost. It also moves the clock polarity between its two values. All-zero, all-one and alternating words, paired with both data-enable values, separate clock-high from clock-low and check the data-enable slot. Frames with gaps in the strobe confirm that the output holds. Frames whose inputs are scrambled after slot 0 show that the word is captured only once per frame. Ending a frame with a high bit and then resetting shows that the remembered polarity is cleared.

// File: rtl/efr_pkg.sv
package efr_pkg;
  typedef enum logic [1:0] {
    SYM_DLO = 2'b00,
    SYM_DHI = 2'b01,
    SYM_CLO = 2'b10,
    SYM_CHI = 2'b11
  } sym_e;
endpackage

// File: rtl/efr_slot_ctr.sv
module efr_slot_ctr #(
  parameter int SLOTS = 36,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [SW-1:0] slot
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      slot <= '0;
    else if (adv)
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
  end
endmodule

// File: rtl/efr_word_latch.sv
module efr_word_latch #(
  parameter int NB = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [NB-1:0] word_in,
  input  logic          de_in,
  output logic [NB-1:0] word_q,
  output logic          de_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      de_q   <= 1'b0;
    end else if (take) begin
      word_q <= word_in;
      de_q   <= de_in;
    end
  end
endmodule

// File: rtl/efr_sym_sel.sv
module efr_sym_sel
  import efr_pkg::*;
#(
  parameter int NB = 30,
  localparam int SLOTS = NB + 6,
  localparam int HALF = SLOTS / 2,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic [SW-1:0] slot,
  input  logic [NB-1:0] word,
  input  logic          de,
  input  logic          last_bit,
  input  logic          tail_inv,
  output sym_e          sym
);
  localparam logic [SW-1:0] S_MID   = SW'(HALF);
  localparam logic [SW-1:0] S_MIDT  = SW'(HALF + 1);
  localparam logic [SW-1:0] S_SPARE = SW'(HALF - 1);
  localparam logic [SW-1:0] S_DE    = SW'(2);
  localparam logic [SW-1:0] S_TAIL  = SW'(1);
  localparam logic [SW-1:0] OFS_A   = SW'(3);
  localparam logic [SW-1:0] OFS_B   = SW'(6);
  localparam int PAD = 1 << SW;

  // word bits in transmit order, zero padded to the index range
  logic [PAD-1:0] order;
  for (genvar i = 0; i < PAD; i++) begin : g_ord
    if (i < NB) begin : g_bit
      assign order[i] = word[NB-1-i];
    end else begin : g_pad
      assign order[i] = 1'b0;
    end
  end

  logic [SW-1:0] idx;
  logic          pay_bit;
  assign idx     = (slot < S_MID) ? slot - OFS_A : slot - OFS_B;
  assign pay_bit = order[idx];

  always_comb begin
    if (slot == '0 || slot == S_MID)
      sym = last_bit ? SYM_CHI : SYM_CLO;
    else if (slot == S_TAIL || slot == S_MIDT)
      sym = (last_bit ^ tail_inv) ? SYM_DHI : SYM_DLO;
    else if (slot == S_DE)
      sym = de ? SYM_DHI : SYM_DLO;
    else if (slot == S_SPARE)
      sym = SYM_DLO;
    else
      sym = pay_bit ? SYM_DHI : SYM_DLO;
  end
endmodule

// File: rtl/emb_clk_framer.sv
module emb_clk_framer
  import efr_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int NB = 3 * DEPTH,
  localparam int SLOTS = NB + 6,
  localparam int HALF = SLOTS / 2,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_en,
  input  logic          tail_inv,
  input  logic          de_in,
  input  logic [NB-1:0] pix_in,
  output logic [1:0]    sym_out
);
  logic [SW-1:0] slot;
  logic [NB-1:0] word_q;
  logic          de_q;
  logic          last_bit;
  logic          take;
  sym_e          nxt;

  assign take = ser_en && (slot == '0);

  efr_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk(clk), .rst(rst), .adv(ser_en), .slot(slot)
  );

  efr_word_latch #(.NB(NB)) u_lat (
    .clk(clk), .rst(rst), .take(take),
    .word_in(pix_in), .de_in(de_in),
    .word_q(word_q), .de_q(de_q)
  );

  efr_sym_sel #(.NB(NB)) u_sel (
    .slot(slot), .word(word_q), .de(de_q),
    .last_bit(last_bit), .tail_inv(tail_inv), .sym(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out  <= 2'b00;
      last_bit <= 1'b0;
    end else if (ser_en) begin
      sym_out <= nxt;
      if (!nxt[1]) last_bit <= nxt[0];
    end
  end
endmodule

// File: rtl/efr_chk.sv
module efr_chk #(
  parameter int SLOTS = 36,
  parameter int HALF = 18,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          ser_en,
  input logic          tail_inv,
  input logic [SW-1:0] slot,
  input logic [1:0]    sym_out
);
  localparam logic [SW-1:0] S_MID  = SW'(HALF);
  localparam logic [SW-1:0] S_MIDT = SW'(HALF + 1);

  logic rst_q = 1'b0;
  always @(posedge clk) begin
    if (rst_q) a_r1_reset_idle: assert (sym_out == 2'b00);
    rst_q <= rst;
  end

  // R2: clock codes only at the two clock slots
  a_r2_clk_slot: assert property (@(posedge clk) disable iff (rst)
    ser_en && (slot == '0 || slot == S_MID) |=> sym_out[1]);
  a_r2_data_slot: assert property (@(posedge clk) disable iff (rst)
    ser_en && !(slot == '0 || slot == S_MID) |=> !sym_out[1]);

  // R3: clock polarity copies the preceding data symbol
  a_r3_clk_pol: assert property (@(posedge clk) disable iff (rst)
    ser_en && (slot == '0 || slot == S_MID) |=> sym_out[0] == $past(sym_out[0]));

  // R4: tail relation to clock polarity
  a_r4_tail: assert property (@(posedge clk) disable iff (rst)
    ser_en && (slot == SW'(1) || slot == S_MIDT)
      |=> sym_out == {1'b0, $past(sym_out[0]) ^ $past(tail_inv)});

  // R8: no strobe, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> $stable(sym_out) && $stable(slot));
endmodule

bind emb_clk_framer efr_chk #(.SLOTS(SLOTS), .HALF(HALF), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .ser_en(ser_en), .tail_inv(tail_inv),
  .slot(slot), .sym_out(sym_out)
);

// File: tb/emb_clk_framer_tb.sv
module emb_clk_framer_tb;
  localparam int DEPTH = 10;
  localparam int NB = 3 * DEPTH;
  localparam int SLOTS = NB + 6;
  localparam int HALF = SLOTS / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_en = 1'b0;
  logic          tail_inv = 1'b0;
  logic          de_in = 1'b0;
  logic [NB-1:0] pix_in = '0;
  logic [1:0]    sym_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic prev_b = 1'b0;
  logic clk_pol = 1'b0;
  bit   done = 0;

  always #10 clk = ~clk;  // 20-unit period: 50 MHz

  emb_clk_framer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ser_en(ser_en), .tail_inv(tail_inv),
    .de_in(de_in), .pix_in(pix_in), .sym_out(sym_out)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sym_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic en);
    @(negedge clk);
    ser_en = en;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ser_en = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R1", sym_out, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", sym_out, 2'b00);
    prev_b = 1'b0;
  endtask

  // expected symbol for slot s of a frame with word p, flag d
  function automatic logic [1:0] expect_sym(input int s, input logic [NB-1:0] p,
                                            input logic d, input logic ti);
    logic b;
    if (s == 0 || s == HALF) begin
      clk_pol = prev_b;
      return {1'b1, prev_b};
    end
    if (s == 1 || s == HALF + 1)   b = clk_pol ^ ti;
    else if (s == 2)               b = d;
    else if (s == HALF - 1)        b = 1'b0;
    else if (s < HALF)             b = p[NB - 1 - (s - 3)];
    else                           b = p[NB - 1 - (s - 6)];
    prev_b = b;
    return {1'b0, b};
  endfunction

  function automatic string tag(input int s);
    if (s == 0 || s == HALF) return "R3";
    if (s == 1 || s == HALF + 1) return "R4";
    if (s == 2) return "R5";
    return "R6";
  endfunction

  task automatic frame(input logic [NB-1:0] p, input logic d, input logic ti,
                       input bit gaps, input bit scramble);
    tail_inv = ti;
    for (int s = 0; s < SLOTS; s++) begin
      logic [1:0] e;
      if (gaps && (s % 7 == 3)) begin
        logic [1:0] held;
        held = sym_out;
        tick(1'b0);
        check("R8", sym_out, held);
      end
      if (s == 0) begin
        pix_in = p;
        de_in = d;
      end
      tick(1'b1);
      e = expect_sym(s, p, d, ti);
      if (scramble) check("R7", sym_out, e);
      else          check(tag(s), sym_out, e);
      if (s == 0 && scramble) begin
        pix_in = ~p;
        de_in = ~d;
      end
    end
  endtask

  initial begin
    do_reset();
    // first clock after reset is low (R3), sweep simple words (R2, R5, R6)
    frame('0, 1'b1, 1'b0, 0, 0);
    frame('1, 1'b1, 1'b0, 0, 0);
    frame({15{2'b10}}, 1'b0, 1'b1, 0, 0);
    frame({15{2'b01}}, 1'b1, 1'b1, 0, 0);
    // walking one over every word bit, both tail settings (R4, R6)
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < NB; i++)
        frame(NB'(1) << i, i[0], t[0], 0, 0);
    // strobe gaps (R8)
    frame(30'h2AB_CDEF, 1'b1, 1'b0, 1, 0);
    frame(30'h154_3210, 1'b0, 1'b1, 1, 0);
    // inputs changed after slot 0 (R7)
    frame(30'h0F0_F0F1, 1'b1, 1'b0, 0, 1);
    frame(30'h30C_30C3, 1'b0, 1'b1, 0, 1);
    // last bit high, then reset clears remembered polarity (R1, R3)
    frame('1, 1'b1, 1'b0, 0, 0);
    do_reset();
    frame(30'h1234_567, 1'b1, 1'b1, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule